// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block drives the serial output of a serial port that runs as a synchronous slave. An external master supplies the serial clock. Upstream logic has already brought that clock, and the serial input line, into the system clock domain. It presents them as single-cycle edge pulses (`sclk_rise`, `sclk_fall`, `din_fall`) and a level (`din_lvl`). The transmitter pulls characters from a show-ahead transmit FIFO. It shifts them out least significant bit first, and the output changes only in response to detected clock activity.

Two framings are supported, and the framing is held constant between resets.

In framed mode, each character carries a start bit and a stop bit. The transmitter works in one of two ways:
- **Master start.** It waits for the master's own start bit. The falling edge on the serial input pulls the slave's start bit low before the first rising sample edge.
- **Continuous clock.** If the very first rising edge after reset finds the serial input high, the master is assumed to be clocking continuously. Characters are then sent as soon as they are available, starting on a falling edge.

In unframed mode, only data bits are sent, while the master clocks. When a transfer begins with nothing to send, a filler character of all ones goes out and an underrun pulse is raised.

Top module: `sstx_top`

## Requirements
- R1: While reset is applied and directly after it, `txd` is 1, `fifo_rd` is 0 and `underrun` is 0.
- R2: `txd` changes only in the cycle after an `sclk_fall` pulse. The one exception is the framed master-start load, which follows a `din_fall` pulse. While no edge pulses arrive, `txd` holds its value.
- R3: A framed character is a 0 start bit, then N data bits least significant bit first, then a 1 stop bit. Each bit is presented to one rising sample edge, in that order.
- R4: In framed mode without continuous clock, a `din_fall` while idle with the FIFO not empty reads one entry. It drives `txd` low in the next cycle, ahead of the next `sclk_rise`.
- R5: In framed mode, if the first `sclk_rise` after reset sees `din_lvl` = 1, the block enters continuous-clock operation. At each idle or end-of-character `sclk_fall` with data queued, it starts the next character with no idle bit between characters. It raises no underrun.
- R6: In framed master-start operation with the FIFO empty, a `din_fall` while idle pulses `underrun` once and sends an all-ones frame of N+2 bits. Any `din_fall` pulses during a character are ignored.
- R7: In unframed mode, a character is N data bits least significant bit first. The first character is loaded at an `sclk_fall` while idle. Later characters follow back to back. A bit advances only at an `sclk_fall` that follows an `sclk_rise` sampling it.
- R8: In unframed mode, an `sclk_rise` while idle (nothing loaded) pulses `underrun` once and sends N ones.
- R9: `fifo_rd` pulses exactly once per character sent from the FIFO. It is only asserted at a character boundary and never while `fifo_empty` is 1.
- R10: N is `char_len` clamped to the range 5 to 9. It is captured when a character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_rise | input | 1 | One-cycle pulse: rising edge of the synchronized serial clock |
| sclk_fall | input | 1 | One-cycle pulse: falling edge of the synchronized serial clock |
| din_lvl | input | 1 | Synchronized level of the serial input line |
| din_fall | input | 1 | One-cycle pulse: high-to-low transition on the serial input |
| framed | input | 1 | 1 = start/stop framing, 0 = data bits only |
| char_len | input | 4 | Requested data bits per character (clamped 5..9) |
| fifo_data | input | 9 | Head entry of the transmit FIFO (show-ahead) |
| fifo_empty | input | 1 | Transmit FIFO holds no entry |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| txd | output | 1 | Serial data output |
| underrun | output | 1 | One-cycle pulse: a transfer began with nothing queued |

## Verification
The bound checker watches several rules on every cycle:
- `txd` moves only after a falling clock pulse, or after a framed master-start edge.
- The FIFO is never popped while empty, and only on a clock or start event.
- A framed load is always followed by a low start bit.
- An unframed load presents data bit 0.
- Underrun pulses only follow an empty FIFO.

The bench scenarios cover what needs a whole character to observe: the bit order and length clamp, the continuous-clock decision from the first sample, back-to-back streaming, filler frames that ignore the master's data edges, and stalls of the serial clock in mid-character.

// File: rtl/sstx_pkg.sv
// Package: shared types for the synchronous slave transmitter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sstx_pkg;

    // Sequencer state: waiting for a character or shifting one out.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } tx_state_e;

    // Number of serial bits in one character for the given data length.
    function automatic int unsigned frame_bits(input int unsigned n, input logic framed);
        return framed ? n + 2 : n;
    endfunction

endpackage

// File: rtl/sstx_mode_track.sv
// Module: sstx_mode_track
// Decides, once per reset, whether a framed master runs a free clock.
// The first event in framed mode settles it. A rising clock edge with the
// input high means continuous clock. A falling input edge (master start
// bit) means per-character clocking.
// Assumes: framed is constant between resets; edge pulses are one cycle.
module sstx_mode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic framed,
    input  logic sclk_rise,
    input  logic din_lvl,
    input  logic din_fall,
    output logic cont
);

    logic decided_q;
    logic cont_q;
    logic first_evt;

    // First qualifying event after reset in framed mode.
    always_comb begin
        first_evt = framed && !decided_q && (sclk_rise || din_fall);
    end

    // Latch the decision once and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !framed) begin
            decided_q <= 1'b0;
            cont_q    <= 1'b0;
        end else if (first_evt) begin
            decided_q <= 1'b1;
            cont_q    <= sclk_rise && din_lvl && !din_fall;
        end
    end

    assign cont = cont_q;

endmodule

// File: rtl/sstx_frame_build.sv
// Module: sstx_frame_build
// Builds the serial bit vector of one character, bit 0 sent first, and
// its length. Framed: start, N data bits, stop. Unframed: N data bits.
// Filler characters are all ones. Unused upper positions are ones.
// Assumes: char_len is clamped here to MIN_LEN..DATA_W.
module sstx_frame_build #(
    parameter int DATA_W  = 9,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = $clog2(DATA_W + 1),
    parameter int FRM_W   = DATA_W + 2,
    parameter int CNT_W   = $clog2(FRM_W + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              framed,
    input  logic              filler,
    output logic [FRM_W-1:0]  frame,
    output logic [CNT_W-1:0]  total
);

    logic [LEN_W-1:0] n;

    // Clamp the requested length into the supported range.
    always_comb begin
        if (char_len < LEN_W'(MIN_LEN))
            n = LEN_W'(MIN_LEN);
        else if (char_len > LEN_W'(DATA_W))
            n = LEN_W'(DATA_W);
        else
            n = char_len;
    end

    // Serial bit count of the character.
    always_comb begin
        total = CNT_W'(sstx_pkg::frame_bits(int'(n), framed));
    end

    // One output position per generated slice.
    for (genvar i = 0; i < FRM_W; i++) begin : g_bit
        logic ub;
        logic fb;
        if (i < DATA_W) begin : g_ud
            assign ub = (LEN_W'(i) < n) ? (data[i] | filler) : 1'b1;
        end else begin : g_un
            assign ub = 1'b1;
        end
        if (i == 0) begin : g_start
            assign fb = filler;
        end else if (i <= DATA_W) begin : g_fd
            assign fb = (LEN_W'(i - 1) < n) ? (data[i-1] | filler) : 1'b1;
        end else begin : g_stop
            assign fb = 1'b1;
        end
        assign frame[i] = framed ? fb : ub;
    end

endmodule

// File: rtl/sstx_bit_seq.sv
// Module: sstx_bit_seq
// Shifts a built character onto txd, one bit per sampled clock period.
// A bit advances at a falling edge only after a rising edge has sampled it.
// Decides when to load from the FIFO, when to send filler, and when a
// character ends.
// Assumes: rising and falling pulses never share a cycle; fifo_data is
// valid whenever fifo_empty is low.
module sstx_bit_seq #(
    parameter int FRM_W = 11,
    parameter int CNT_W = $clog2(FRM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             framed,
    input  logic             cont,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             din_fall,
    input  logic             fifo_empty,
    input  logic [FRM_W-1:0] frame,
    input  logic [CNT_W-1:0] total,
    output logic             fill_start,
    output logic             load,
    output logic             txd,
    output logic             underrun
);
    import sstx_pkg::*;

    tx_state_e        state_q;
    logic [FRM_W-1:0] shift_q;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] pos_q;
    logic             pending_q;
    logic             txd_q;
    logic             underrun_q;

    logic busy;
    logic last_bit;
    logic at_end;
    logic advance;
    logic stream_mode;
    logic boundary_fall;
    logic master_start;

    // Event decode for the current cycle.
    always_comb begin
        busy          = (state_q == ST_SHIFT);
        last_bit      = (pos_q == total_q - CNT_W'(1));
        at_end        = busy && sclk_fall && pending_q && last_bit;
        advance       = busy && sclk_fall && pending_q && !last_bit;
        stream_mode   = !framed || cont;
        boundary_fall = sclk_fall && (!busy || at_end);
        master_start  = framed && !cont && !busy && din_fall;
        load          = !fifo_empty && ((stream_mode && boundary_fall) || master_start);
        fill_start    = (!framed && !busy && sclk_rise) || (master_start && fifo_empty);
    end

    // Character state, bit position and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            shift_q   <= '1;
            total_q   <= '0;
            pos_q     <= '0;
            pending_q <= 1'b0;
            txd_q     <= 1'b1;
        end else if (load || fill_start) begin
            state_q   <= ST_SHIFT;
            shift_q   <= frame;
            total_q   <= total;
            pos_q     <= '0;
            pending_q <= fill_start && !framed;
            txd_q     <= frame[0];
        end else if (at_end) begin
            state_q   <= ST_IDLE;
            pending_q <= 1'b0;
            txd_q     <= 1'b1;
        end else if (advance) begin
            shift_q   <= {1'b1, shift_q[FRM_W-1:1]};
            pos_q     <= pos_q + CNT_W'(1);
            pending_q <= 1'b0;
            txd_q     <= shift_q[1];
        end else if (busy && sclk_rise) begin
            pending_q <= 1'b1;
        end
    end

    // Underrun pulse, one cycle after a filler character begins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            underrun_q <= 1'b0;
        else
            underrun_q <= fill_start;
    end

    assign txd      = txd_q;
    assign underrun = underrun_q;

endmodule

// File: rtl/sstx_top.sv
// Module: sstx_top
// Synchronous slave serial transmitter. Combines the mode tracker, the
// character builder and the bit sequencer. fifo_rd pops a show-ahead FIFO.
// Assumes: serial clock and input already synchronized to clk and given
// as edge pulses; framed and char_len change only between characters.
module sstx_top #(
    parameter int DATA_W  = 9,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_lvl,
    input  logic              din_fall,
    input  logic              framed,
    input  logic [LEN_W-1:0]  char_len,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    output logic              txd,
    output logic              underrun
);

    localparam int FRM_W = DATA_W + 2;
    localparam int CNT_W = $clog2(FRM_W + 1);

    logic             cont;
    logic             fill_start;
    logic             load;
    logic [FRM_W-1:0] frame;
    logic [CNT_W-1:0] total;

    sstx_mode_track u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .framed    (framed),
        .sclk_rise (sclk_rise),
        .din_lvl   (din_lvl),
        .din_fall  (din_fall),
        .cont      (cont)
    );

    sstx_frame_build #(
        .DATA_W  (DATA_W),
        .MIN_LEN (MIN_LEN),
        .LEN_W   (LEN_W),
        .FRM_W   (FRM_W),
        .CNT_W   (CNT_W)
    ) u_build (
        .data     (fifo_data),
        .char_len (char_len),
        .framed   (framed),
        .filler   (fill_start),
        .frame    (frame),
        .total    (total)
    );

    sstx_bit_seq #(
        .FRM_W (FRM_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .framed     (framed),
        .cont       (cont),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .din_fall   (din_fall),
        .fifo_empty (fifo_empty),
        .frame      (frame),
        .total      (total),
        .fill_start (fill_start),
        .load       (load),
        .txd        (txd),
        .underrun   (underrun)
    );

    assign fifo_rd = load;

endmodule

// File: rtl/sstx_checker.sv
// Module: sstx_checker
// Cycle-level rules of the transmitter, attached to sstx_top by bind.
// Assumes: synchronous active-low reset.
module sstx_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic din_fall,
    input logic framed,
    input logic fd0,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic txd,
    input logic underrun
);

    // R2: output moves only after a falling clock or a framed start edge
    a_r2_txd_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (txd != $past(txd)) |-> $past(sclk_fall || (framed && din_fall)));

    // R9: never pop an empty FIFO
    a_r9_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R9: pops only on a falling clock or a framed start edge
    a_r9_read_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (sclk_fall || (framed && din_fall)));

    // R4: a framed load is followed by a low start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && fifo_rd) |=> !txd);

    // R7: an unframed load presents data bit 0
    a_r7_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!framed && fifo_rd) |=> (txd == $past(fd0)));

    // R6: underrun only follows an empty FIFO and a transfer start event
    a_r6_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(fifo_empty && (sclk_rise || din_fall)));

endmodule

bind sstx_top sstx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .din_fall   (din_fall),
    .framed     (framed),
    .fd0        (fifo_data[0]),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .txd        (txd),
    .underrun   (underrun)
);

// File: tb/test_sstx_top.sv
module test_sstx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_rise = 1'b0;
    logic       sclk_fall = 1'b0;
    logic       din_lvl = 1'b1;
    logic       din_fall = 1'b0;
    logic       framed = 1'b1;
    logic [3:0] char_len = 4'd8;
    logic [8:0] fifo_data;
    logic       fifo_empty;
    logic       fifo_rd;
    logic       txd;
    logic       underrun;

    logic [8:0] mem [64];
    logic [6:0] wr = '0;
    logic [6:0] rd = '0;
    int         ucnt = 0;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    assign fifo_empty = (wr == rd);
    assign fifo_data  = mem[rd[5:0]];

    // Bench FIFO read side and underrun counter.
    always @(posedge clk) begin
        if (!rst_n) rd <= wr;
        else if (fifo_rd) rd <= rd + 7'd1;
        if (rst_n && underrun) ucnt <= ucnt + 1;
    end

    sstx_top i_sstx_top (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .din_lvl(din_lvl), .din_fall(din_fall), .framed(framed), .char_len(char_len),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .txd(txd), .underrun(underrun)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clamp_n(input logic [3:0] l);
        if (l < 5) return 5;
        if (l > 9) return 9;
        return int'(l);
    endfunction

    function automatic logic [15:0] exp_bits(input logic [8:0] d, input int n, input bit fr, input bit fill);
        logic [15:0] r = '1;
        int k = 0;
        if (fr) begin r[0] = fill; k = 1; end
        for (int i = 0; i < n; i++) r[k+i] = fill ? 1'b1 : d[i];
        return r;
    endfunction

    task automatic push(input logic [8:0] v);
        mem[wr[5:0]] = v;
        wr = wr + 7'd1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic lone_fall();
        @(negedge clk); sclk_fall = 1;
        @(negedge clk); sclk_fall = 0;
    endtask

    // One master bit: drive din, then rise (sample txd), then fall.
    task automatic mbit(input logic b, output logic s);
        @(negedge clk);
        din_fall = din_lvl & ~b;
        din_lvl  = b;
        @(negedge clk); din_fall = 0;
        @(negedge clk);
        s = txd; sclk_rise = 1;
        @(negedge clk); sclk_rise = 0;
        @(negedge clk);
        @(negedge clk); sclk_fall = 1;
        @(negedge clk); sclk_fall = 0;
    endtask

    task automatic master_frame(input logic [8:0] md, input int n, output logic [15:0] got);
        logic s;
        got = '1;
        for (int i = 0; i < n + 2; i++) begin
            logic b;
            b = (i == 0) ? 1'b0 : (i <= n) ? md[i-1] : 1'b1;
            mbit(b, s);
            got[i] = s;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic [63:0] stream;
        logic [63:0] expst;
        logic        s;
        logic [8:0]  d;
        int          n;
        int          u0;
        logic [6:0]  r0;

        // R1 reset state
        repeat (2) @(negedge clk);
        chk("R1 txd in reset", txd, 1);
        chk("R1 fifo_rd in reset", fifo_rd, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 underrun after reset", underrun, 0);

        // R2/R9: framed, data queued, clock stopped: nothing moves
        framed = 1; do_reset();
        push(9'h0A5);
        r0 = rd;
        repeat (40) begin @(negedge clk); if (txd !== 1'b1) chk("R2 stopped clock txd", txd, 1); end
        chk("R9 no read while stopped", rd, r0);

        // R3/R4/R10: master-start framed characters, random data and length
        for (int c = 0; c < 14; c++) begin
            char_len = (c == 0) ? 4'd8 : (c == 1) ? 4'd2 : (c == 2) ? 4'd13 : 4'($urandom_range(0, 15));
            n = clamp_n(char_len);
            if (c == 0) d = 9'h0A5;
            else begin d = 9'($urandom); push(d); end
            r0 = rd;
            master_frame(9'($urandom), n, got);
            chk($sformatf("R3 R4 R10 framed char %0d len %0d", c, n), got, exp_bits(d, n, 1, 0));
            chk("R9 one read per framed char", rd - r0, 1);
            repeat ($urandom_range(0, 6)) @(negedge clk);
        end

        // R6: underrun with empty FIFO; din falls inside the char ignored
        char_len = 4'd8; u0 = ucnt;
        master_frame(9'h0AA, 8, got);
        chk("R6 filler frame", got, exp_bits(9'h0, 8, 1, 1));
        chk("R6 underrun pulse count", ucnt - u0, 1);
        push(9'h13C);
        master_frame(9'h055, 8, got);
        chk("R6 recovery after filler", got, exp_bits(9'h13C, 8, 1, 0));

        // R5: continuous clock, back-to-back characters
        framed = 1; char_len = 4'd8; do_reset();
        push(9'h0C3); push(9'h011); push(9'h1FE);
        u0 = ucnt; stream = '1;
        for (int i = 0; i < 36; i++) begin
            mbit(1'b1, s); stream[i] = s;
            if (i == 13) begin
                logic t0;
                t0 = txd;
                repeat (30) @(negedge clk);
                chk("R2 continuous mid-char stall", txd, t0);
            end
        end
        expst = '1;
        expst[10:1]  = exp_bits(9'h0C3, 8, 1, 0)[9:0];
        expst[20:11] = exp_bits(9'h011, 8, 1, 0)[9:0];
        expst[30:21] = exp_bits(9'h1FE, 8, 1, 0)[9:0];
        chk("R5 continuous stream", stream, expst);
        chk("R5 no underrun in continuous", ucnt - u0, 0);
        chk("R9 three reads in continuous", wr - rd, 0);

        // R7/R8: unframed streaming
        for (int pass = 0; pass < 2; pass++) begin
            logic [8:0] q [4];
            framed = 0; char_len = (pass == 0) ? 4'd7 : 4'd9; do_reset();
            n = clamp_n(char_len);
            for (int k = 0; k < 4; k++) begin q[k] = 9'($urandom); push(q[k]); end
            lone_fall();
            for (int k = 0; k < 4; k++) begin
                got = '1;
                for (int i = 0; i < n; i++) begin
                    mbit(1'($urandom), s); got[i] = s;
                    if (k == 1 && i == 2) begin
                        logic t0;
                        t0 = txd;
                        repeat (25) @(negedge clk);
                        chk("R2 unframed mid-char stall", txd, t0);
                    end
                end
                chk($sformatf("R7 unframed char %0d len %0d", k, n), got, exp_bits(q[k], n, 0, 0));
            end
            chk("R9 four unframed reads", wr - rd, 0);
            u0 = ucnt; got = '1;
            for (int i = 0; i < n; i++) begin mbit(1'($urandom), s); got[i] = s; end
            chk("R8 unframed filler", got, 16'hFFFF);
            chk("R8 unframed underrun count", ucnt - u0, 1);
            d = 9'($urandom); push(d);
            lone_fall();
            got = '1;
            for (int i = 0; i < n; i++) begin mbit(1'($urandom), s); got[i] = s; end
            chk("R7 unframed after filler", got, exp_bits(d, n, 0, 0));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule